// File: doc/BRIEF.md
# Byte-to-Word Store Write Adapter

This block lets a byte-oriented client read, write and erase a non-volatile store that can only be reached one 16-bit word at a time. The client hands over one request: an operation, a start byte address and a byte count. The adapter then walks the range, one word per step. For each word it issues a command and waits for the store's done indication, giving up after a bounded number of wait cycles.

A word that the request covers only partly is handled by read-modify-write, so its other byte is kept. This happens for an odd start byte and for a single trailing even byte. Erase uses the write path with every byte forced to all ones. A read unpacks each fetched word into bytes, starting at the high byte when the start address is odd and stopping at the requested count.

Write bytes arrive on a valid/ready stream and read bytes leave on one. The adapter takes a write byte only when `wr_valid` and `wr_ready` are both high at a clock edge. It holds `rd_data` steady while `rd_valid` is high and `rd_ready` is low. Either side may stall for any number of cycles. The request port is also valid/ready, and `req_ready` is high only while the adapter is idle. `wr_ready` and `rd_valid` depend only on internal state, never on the partner's signal. The word address field holds up to 14 bits, so `AW` may be at most 15.

Top module: `bw_store_adapter`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `st_cmd_valid` are low and `req_ready` is high.
- R2: Word address = byte address >> 1. The even byte sits in word bits 7:0 and the odd byte in bits 15:8. Each command word has a start bit at 0, a done bit at 1 (always issued as 0), the word address from bit 2 upward and 16 data bits at 31:16. `st_cmd_write` is 1 for a word write and 0 for a word read.
- R3: A write or erase starting at an odd byte address first reads that word. It writes the word back with the old low byte and the new high byte.
- R4: When exactly one byte of a write or erase remains at an even address, the adapter reads that word first. It writes the word back with the old high byte and the new low byte.
- R5: A word fully covered by a write or erase is written with a single command and no read.
- R6: Erase (`req_op` = 2) writes 0xFF to every addressed byte and takes nothing from the write stream. Write is `req_op` = 1; 0 and 3 are reads.
- R7: A read issues one word read per word touched. It delivers exactly `req_len` bytes in ascending address order, taking the high byte first when the start address is odd.
- R8: Each command waits for `st_done` for at most `POLL_LIMIT` cycles, and done on the last allowed cycle still succeeds. If done is absent, the operation aborts and `err_o` is high with `done_o`; otherwise `err_o` is low with `done_o`.
- R9: A zero-length request raises `done_o` two cycles after acceptance, issues no command and reports no error.
- R10: `busy_o` is high from the cycle after acceptance through the single-cycle `done_o` pulse. Stream and command activity happen only while busy.
- R11: `rd_data` stays stable while `rd_valid` is high and `rd_ready` is low. A write byte is consumed only on a `wr_valid` and `wr_ready` handshake.
- R12: `st_cmd_valid` lasts one cycle per command, and one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Adapter idle, request taken at this edge |
| req_op | input | 2 | 0/3 read, 1 write, 2 erase |
| req_addr | input | AW | Start byte address |
| req_len | input | AW+1 | Byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Adapter accepts a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Client accepts the read byte |
| rd_data | output | 8 | Read byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout error, valid with done_o |
| st_cmd_valid | output | 1 | Store command strobe |
| st_cmd_write | output | 1 | 1 word write, 0 word read |
| st_cmd_word | output | 32 | Command word |
| st_done | input | 1 | Store completion |
| st_rdata | input | 16 | Read word, valid with st_done |

## Verification
The hardest situation to reach from the ports is a store completion on exactly the last allowed wait cycle, which must succeed, compared with one cycle later, which must abort. The bench gives its store model a latency per operation and lowers `POLL_LIMIT`, so both sides of the boundary are driven deliberately. The partial-word merges need odd starts and odd tails to meet stalls on both streams. The bench therefore runs unaligned requests while irregular valid and ready patterns are applied.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_ERASE = 2'd2;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_DONE_BIT = 1;
  localparam int CMD_ADDR_LSB = 2;
  localparam int CMD_DATA_LSB = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_RD_ISSUE, S_RD_WAIT, S_GATHER,
    S_WR_ISSUE, S_WR_WAIT, S_EMIT, S_DONE
  } state_e;
endpackage

// File: rtl/bwa_cmd_pack.sv
module bwa_cmd_pack
  import bwa_pkg::*;
#(
  parameter int WAW = 11
) (
  input  logic [WAW-1:0] waddr,
  input  logic [15:0]    wdata,
  output logic [31:0]    word
);
  always_comb begin
    word = '0;
    word[CMD_GO_BIT] = 1'b1;
    word[CMD_DONE_BIT] = 1'b0;
    word[CMD_ADDR_LSB +: WAW] = waddr;
    word[CMD_DATA_LSB +: 16] = wdata;
  end
endmodule

// File: rtl/bwa_step_plan.sv
module bwa_step_plan #(
  parameter int LW = 13
) (
  input  logic          odd,
  input  logic [LW-1:0] rem,
  output logic          partial
);
  // A step covers one byte when it starts odd or when only one byte is left.
  assign partial = odd || (rem == LW'(1));
endmodule

// File: rtl/bwa_poll_timer.sv
module bwa_poll_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clear)          cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  // R8
  expire_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !expired || (LIMIT == 1));
endmodule

// File: rtl/bw_store_adapter.sv
module bw_store_adapter
  import bwa_pkg::*;
#(
  parameter int AW         = 12,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [AW:0]   req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [7:0]    rd_data,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          st_cmd_valid,
  output logic          st_cmd_write,
  output logic [31:0]   st_cmd_word,
  input  logic          st_done,
  input  logic [15:0]   st_rdata
);
  localparam int WAW = AW - 1;
  localparam int LW  = AW + 1;

  state_e        state;
  logic [1:0]    op_q;
  logic [AW-1:0] baddr;
  logic [LW-1:0] rem;
  logic [15:0]   word_q;
  logic          gidx;
  logic          err_q;

  logic          is_read, is_erase, partial, last_byte, pos_hi;
  logic          gtake, expired, t_clear, t_run;
  logic [7:0]    gbyte;
  logic [AW-1:0] step_a;
  logic [LW-1:0] step_r;

  assign is_erase  = (op_q == OP_ERASE);
  assign is_read   = !(op_q == OP_WRITE || is_erase);

  bwa_step_plan #(.LW(LW)) u_plan (
    .odd(baddr[0]), .rem(rem), .partial(partial)
  );

  assign last_byte = partial || gidx;
  assign pos_hi    = baddr[0] || gidx;
  assign step_a    = partial ? AW'(1) : AW'(2);
  assign step_r    = partial ? LW'(1) : LW'(2);
  assign gbyte     = is_erase ? 8'hFF : wr_data;
  assign gtake     = is_erase || wr_valid;

  assign t_clear = (state == S_RD_ISSUE) || (state == S_WR_ISSUE);
  assign t_run   = (state == S_RD_WAIT)  || (state == S_WR_WAIT);

  bwa_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(t_clear), .run(t_run), .expired(expired)
  );

  bwa_cmd_pack #(.WAW(WAW)) u_pack (
    .waddr(baddr[AW-1:1]),
    .wdata((state == S_WR_ISSUE) ? word_q : 16'h0000),
    .word(st_cmd_word)
  );

  assign req_ready    = (state == S_IDLE);
  assign busy_o       = (state != S_IDLE);
  assign done_o       = (state == S_DONE);
  assign err_o        = (state == S_DONE) && err_q;
  assign st_cmd_valid = t_clear;
  assign st_cmd_write = (state == S_WR_ISSUE);
  assign wr_ready     = (state == S_GATHER) && (op_q == OP_WRITE);
  assign rd_valid     = (state == S_EMIT);
  assign rd_data      = pos_hi ? word_q[15:8] : word_q[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= '0;
      baddr  <= '0;
      rem    <= '0;
      word_q <= '0;
      gidx   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q  <= req_op;
          baddr <= req_addr;
          rem   <= req_len;
          err_q <= 1'b0;
          state <= S_SETUP;
        end
        S_SETUP: begin
          gidx <= 1'b0;
          if (rem == '0)                state <= S_DONE;
          else if (is_read || partial)  state <= S_RD_ISSUE;
          else                          state <= S_GATHER;
        end
        S_RD_ISSUE: state <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (st_done) begin
            word_q <= st_rdata;
            state  <= is_read ? S_EMIT : S_GATHER;
          end else if (expired) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end
        end
        S_GATHER: if (gtake) begin
          if (pos_hi) word_q[15:8] <= gbyte;
          else        word_q[7:0]  <= gbyte;
          if (last_byte) begin
            gidx  <= 1'b0;
            state <= S_WR_ISSUE;
          end else begin
            gidx <= 1'b1;
          end
        end
        S_WR_ISSUE: state <= S_WR_WAIT;
        S_WR_WAIT: begin
          if (st_done) begin
            baddr <= baddr + step_a;
            rem   <= rem - step_r;
            state <= S_SETUP;
          end else if (expired) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end
        end
        S_EMIT: if (rd_ready) begin
          if (last_byte) begin
            baddr <= baddr + step_a;
            rem   <= rem - step_r;
            state <= S_SETUP;
          end else begin
            gidx <= 1'b1;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_cmd_valid |=> !st_cmd_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  // R10
  active_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_ready || st_cmd_valid) |-> busy_o);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_data));

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |-> ##2 (done_o && !err_o));
endmodule

// File: tb/tb_bw_store_adapter.sv
module tb_bw_store_adapter;
  localparam int AW    = 6;
  localparam int LIMIT = 6;
  localparam int NW    = 1 << (AW - 1);
  localparam int NB    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [AW:0]   req_len = '0;
  logic          wr_valid = 1'b0, wr_ready;
  logic [7:0]    wr_data = '0;
  logic          rd_valid, rd_ready = 1'b0;
  logic [7:0]    rd_data;
  logic          busy_o, done_o, err_o;
  logic          st_cmd_valid, st_cmd_write;
  logic [31:0]   st_cmd_word;
  logic          st_done = 1'b0;
  logic [15:0]   st_rdata = '0;

  bw_store_adapter #(.AW(AW), .POLL_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .st_cmd_valid(st_cmd_valid), .st_cmd_write(st_cmd_write),
    .st_cmd_word(st_cmd_word), .st_done(st_done), .st_rdata(st_rdata)
  );

  always #5 clk = ~clk;

  int vectors = 0, misses = 0;
  int cmds = 0, lat = 1, pend = 0, cyc = 0;
  logic [31:0] c_word;
  logic        c_write;
  logic [15:0] smem [NW];
  logic [7:0]  refb [NB];
  logic [7:0]  wq[$];
  logic [7:0]  rq[$];
  bit          finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Word store model: latency counted in cycles after the command cycle.
  initial forever begin
    @(negedge clk);
    if (st_done) st_done = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        if (c_write) smem[c_word[2 +: AW-1]] = c_word[31:16];
        else         st_rdata = smem[c_word[2 +: AW-1]];
        st_done = 1'b1;
      end
    end
    if (st_cmd_valid) begin
      cmds++;
      c_word  = st_cmd_word;
      c_write = st_cmd_write;
      pend    = lat;
      chk(st_cmd_word[1:0] == 2'b01, "R2 command start/done bits", st_cmd_word[1:0], 2'b01);
    end
  end

  // Stream drivers and per-clock comparison against the reference queues.
  initial forever begin
    @(negedge clk);
    cyc++;
    wr_valid = (wq.size() > 0) && (cyc % 3 != 1);
    wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
    if (wr_valid && wr_ready) void'(wq.pop_front());
    rd_ready = (cyc % 4 != 2);
    if (rd_valid && rd_ready) begin
      if (rq.size() == 0) chk(1'b0, "R7 unexpected read byte", rd_data, 0);
      else begin
        chk(rd_data == rq[0], "R7 read byte", rd_data, rq[0]);
        void'(rq.pop_front());
      end
    end
    if (rst_n && (rd_valid || wr_ready || st_cmd_valid) && !busy_o)
      chk(1'b0, "R10 activity while idle", busy_o, 1);
  end

  task automatic run_op(input logic [1:0] op, input int addr, input int len,
                        input int lat_i, input bit exp_err, input int seed, input string tag);
    int exp_cmds, c0, waits, bad;
    exp_cmds = 0;
    rq.delete();
    for (int i = 0; i < len; i++) begin
      int a;
      logic [7:0] b;
      a = addr + i;
      b = 8'((seed * 37) + (i * 13) + 5);
      if (op == 2'd1) begin wq.push_back(b); refb[a] = b; end
      else if (op == 2'd2) refb[a] = 8'hFF;
      else rq.push_back(refb[a]);
    end
    if (len > 0)
      for (int w = addr / 2; w <= (addr + len - 1) / 2; w++) begin
        if (op == 2'd1 || op == 2'd2)
          exp_cmds += ((2 * w >= addr) && (2 * w + 1 <= addr + len - 1)) ? 1 : 2;
        else exp_cmds += 1;
      end
    lat = lat_i;
    c0  = cmds;
    req_op = op; req_addr = AW'(addr); req_len = (AW+1)'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waits = 0;
    while (!done_o && waits < 2000) begin
      @(negedge clk);
      waits++;
    end
    chk(done_o, {tag, " completion seen"}, done_o, 1);
    chk(err_o == exp_err, {tag, " error flag"}, err_o, exp_err);
    if (len == 0) chk(waits == 1, "R9 zero-length latency", waits, 1);
    if (!exp_err) begin
      chk(cmds - c0 == exp_cmds, {tag, " command count"}, cmds - c0, exp_cmds);
      chk(rq.size() == 0, {tag, " read bytes delivered"}, rq.size(), 0);
      chk(wq.size() == 0, {tag, " write bytes consumed"}, wq.size(), 0);
      bad = 0;
      for (int w = 0; w < NW; w++)
        if (smem[w] != {refb[2*w+1], refb[2*w]}) bad++;
      chk(bad == 0, {tag, " store image"}, bad, 0);
    end
    rq.delete();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin
      smem[w] = 16'(16'hA05A + w * 16'h0321);
      refb[2*w]   = smem[w][7:0];
      refb[2*w+1] = smem[w][15:8];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o, "R1 busy after reset", busy_o, 0);
    chk(!done_o, "R1 done after reset", done_o, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(!st_cmd_valid, "R1 no command after reset", st_cmd_valid, 0);

    run_op(2'd0, 4, 6, 1, 0, 0, "R7 aligned read");
    run_op(2'd0, 7, 4, 3, 0, 0, "R7 odd-start read");
    run_op(2'd3, 16, 3, 2, 0, 0, "R7 op3 read");
    run_op(2'd1, 10, 4, 2, 0, 1, "R5 aligned write");
    run_op(2'd1, 21, 5, 4, 0, 2, "R3 odd-start write");
    run_op(2'd1, 30, 3, 1, 0, 3, "R4 tail-byte write");
    run_op(2'd1, 1, 1, 2, 0, 4, "R3 single odd byte");
    run_op(2'd1, 50, 1, 3, 0, 5, "R4 single even byte");
    run_op(2'd2, 41, 6, 2, 0, 0, "R6 unaligned erase");
    run_op(2'd2, 56, 4, 1, 0, 0, "R6 aligned erase");
    run_op(2'd1, 12, 0, 1, 0, 6, "R9 zero-length write");
    run_op(2'd0, 3, 0, 1, 0, 0, "R9 zero-length read");
    run_op(2'd0, 8, 2, LIMIT, 0, 0, "R8 done on last attempt");
    run_op(2'd0, 8, 2, LIMIT + 1, 1, 0, "R8 timeout");
    run_op(2'd1, 34, 3, LIMIT, 0, 7, "R8 write at limit");
    run_op(2'd0, 0, NB, 2, 0, 0, "R2 full readback");
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule